// File: doc/BRIEF.md
# Nested-Call State Machine Controller

This block is a control unit whose behaviour lives entirely in a writable transition memory. An algorithm is split into modules that call each other the way subroutines do. Two parallel stacks track the nesting. One stack holds the module code of every active level. The other holds one state code per level. Every active step reads one table entry, addressed by the segment select, the top module code, the top state code and the external inputs. That entry supplies the next state, the registered output vector and an operation code. The operation is a plain step, a call into another module, or a return to the caller.

The transition memory is filled through a configuration write port. Writes are accepted only while the machine is stopped or finished. A segment-select input picks one of several table images, so a whole behaviour can be swapped without rewriting the memory. Because the table is indexed by module code, two modules may use the same state code and still follow different transitions.

Top module: `nested_fsm`

## Requirements
- R1: After reset, both stacks hold a single level with module 0 and state 0, the output vector `y` is zero, and `done` and `overflow` are low.
- R2: The table address is the concatenation {seg, top module, top state, x}, with `seg` in the most significant bits and `x` in the least. An entry holds the next state in bits [2:0], the output vector in bits [6:3], the callee module in bits [8:7] and the operation in bits [10:9]. Operation 0 and operation 3 are plain steps, 1 is a call and 2 is a return.
- R3: An active cycle is one with `run` high and `done` low. On an active cycle with a plain step, the top state becomes the entry's next state, and `y` takes the entry's output vector at the same clock edge.
- R4: On an active call that is not at full depth, the caller's top state is replaced by the entry's next state, which becomes its return point. The callee module is then pushed with state 0, and `y` takes the entry's output vector.
- R5: On an active return above the outermost level, both stacks pop, so the caller resumes at its saved return state. `y` takes the entry's output vector.
- R6: An active return at the outermost level sets `done`, and `y` takes the entry's output vector. While `done` is high, nothing but reset changes the stacks, `y` or `done`.
- R7: An active call made when the stacks are at depth DEPTH sets a sticky `overflow` flag. The call is otherwise ignored: the stacks and `y` keep their values.
- R8: While `run` is low, the stacks and `y` hold their values whatever `x` and `seg` do.
- R9: A configuration write takes effect only in a cycle where `run` is low or `done` is high. In any other cycle it is discarded.
- R10: Changing `seg` between active cycles makes the very next step use the entry from the newly selected table image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Advance one transition per cycle while high |
| seg | input | SEG_W | Table image select |
| x | input | X_W | External inputs returned from the datapath |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | AW | Table write address |
| cfg_data | input | EW | Table write data |
| y | output | Y_W | Registered output vector to the datapath |
| done | output | 1 | Outermost module has returned |
| overflow | output | 1 | Sticky flag: a call was refused at full depth |
| cur_mod | output | MOD_W | Module code on top of the module stack |
| cur_state | output | ST_W | State code on top of the state stack |

## Verification
The bench goes after several corner cases. The first is a call at full depth: a design that pushed anyway would wrap the stack pointer and corrupt the caller levels, and one that still updated `y` would show an output the refused call should not produce. The second is a return after nested calls: a design that pushed state 0 without first saving the return state would resume the caller at the wrong code. The third is a return from the outermost module, after which a machine that kept stepping would change `y` while `done` is high. The last two are table writes attempted mid-run, which must be dropped, and segment switches, which must redirect the very next lookup. Long random tables with mixed calls and returns are checked on every cycle against an independent stack model.

// File: rtl/nfsm_pkg.sv
package nfsm_pkg;

    // Operation field of a table entry
    typedef enum logic [1:0] {
        OP_STEP = 2'd0,
        OP_CALL = 2'd1,
        OP_RET  = 2'd2,
        OP_ALT  = 2'd3
    } op_e;

    localparam int OP_W = 2;

endpackage

// File: rtl/nfsm_stack.sv
module nfsm_stack #(
    parameter  int W     = 3,
    parameter  int DEPTH = 4,
    localparam int SPW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic           pop,
    input  logic           wr_top,
    input  logic [W-1:0]   top_val,
    input  logic [W-1:0]   push_val,
    output logic [W-1:0]   top,
    output logic [SPW-1:0] level,
    output logic           full,
    output logic           empty
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [SPW-1:0]          sp;
    } stk_t;

    stk_t s_d, s_q;

    assign top   = s_q.mem[s_q.sp];
    assign level = s_q.sp;
    assign full  = (s_q.sp == SPW'(DEPTH - 1));
    assign empty = (s_q.sp == '0);

    always_comb begin
        s_d = s_q;
        if (wr_top) begin
            s_d.mem[s_q.sp] = top_val;
        end
        if (push && !full) begin
            s_d.sp          = s_q.sp + SPW'(1);
            s_d.mem[s_d.sp] = push_val;
        end else if (pop && !empty) begin
            s_d.sp = s_q.sp - SPW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));                                                   // R4
    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> (level == $past(level) + SPW'(1)));            // R4
    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty) |=> (level == $past(level) - SPW'(1)));            // R5
    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(level) <= DEPTH - 1));                                       // R7

endmodule

// File: rtl/nfsm_table.sv
module nfsm_table #(
    parameter  int AW      = 8,
    parameter  int EW      = 11,
    localparam int ENTRIES = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [EW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [EW-1:0] rdata
);

    logic [EW-1:0] ram_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) begin
            ram_q[waddr] <= wdata;
        end
    end

    assign rdata = ram_q[raddr];

endmodule

// File: rtl/nested_fsm.sv
module nested_fsm
    import nfsm_pkg::*;
#(
    parameter  int X_W   = 2,
    parameter  int Y_W   = 4,
    parameter  int MOD_W = 2,
    parameter  int ST_W  = 3,
    parameter  int DEPTH = 4,
    parameter  int SEG_W = 1,
    localparam int AW    = SEG_W + MOD_W + ST_W + X_W,
    localparam int EW    = OP_W + MOD_W + Y_W + ST_W,
    localparam int LVL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEG_W-1:0] seg,
    input  logic [X_W-1:0]   x,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [EW-1:0]    cfg_data,
    output logic [Y_W-1:0]   y,
    output logic             done,
    output logic             overflow,
    output logic [MOD_W-1:0] cur_mod,
    output logic [ST_W-1:0]  cur_state
);

    typedef struct packed {
        logic [Y_W-1:0] y;
        logic           done;
        logic           ovf;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [AW-1:0]    rd_addr;
    logic [EW-1:0]    rd_entry;
    logic [ST_W-1:0]  e_state;
    logic [Y_W-1:0]   e_y;
    logic [MOD_W-1:0] e_callee;
    op_e              e_op;

    logic             m_push_d, m_pop_d;
    logic             s_push_d, s_pop_d, s_wr_d;
    logic             tbl_we_d;
    logic             step_d;

    logic [LVL_W-1:0] m_level, s_level;
    logic             m_full, m_empty, s_full, s_empty;

    // Transition lookup
    assign rd_addr  = {seg, cur_mod, cur_state, x};
    assign e_state  = rd_entry[ST_W-1:0];
    assign e_y      = rd_entry[ST_W +: Y_W];
    assign e_callee = rd_entry[ST_W + Y_W +: MOD_W];
    assign e_op     = op_e'(rd_entry[EW-1 -: OP_W]);

    nfsm_table #(.AW(AW), .EW(EW)) u_table (
        .clk   (clk),
        .we    (tbl_we_d),
        .waddr (cfg_addr),
        .wdata (cfg_data),
        .raddr (rd_addr),
        .rdata (rd_entry)
    );

    nfsm_stack #(.W(MOD_W), .DEPTH(DEPTH)) u_mod_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (m_push_d),
        .pop      (m_pop_d),
        .wr_top   (1'b0),
        .top_val  ('0),
        .push_val (e_callee),
        .top      (cur_mod),
        .level    (m_level),
        .full     (m_full),
        .empty    (m_empty)
    );

    nfsm_stack #(.W(ST_W), .DEPTH(DEPTH)) u_state_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (s_push_d),
        .pop      (s_pop_d),
        .wr_top   (s_wr_d),
        .top_val  (e_state),
        .push_val ('0),
        .top      (cur_state),
        .level    (s_level),
        .full     (s_full),
        .empty    (s_empty)
    );

    always_comb begin
        c_d      = c_q;
        m_push_d = 1'b0;
        m_pop_d  = 1'b0;
        s_push_d = 1'b0;
        s_pop_d  = 1'b0;
        s_wr_d   = 1'b0;
        step_d   = run && !c_q.done;
        tbl_we_d = cfg_we && (!run || c_q.done);
        if (step_d) begin
            unique case (e_op)
                OP_CALL: begin
                    if (m_full) begin
                        c_d.ovf = 1'b1;
                    end else begin
                        c_d.y    = e_y;
                        s_wr_d   = 1'b1;
                        s_push_d = 1'b1;
                        m_push_d = 1'b1;
                    end
                end
                OP_RET: begin
                    c_d.y = e_y;
                    if (m_empty) begin
                        c_d.done = 1'b1;
                    end else begin
                        m_pop_d = 1'b1;
                        s_pop_d = 1'b1;
                    end
                end
                default: begin
                    c_d.y  = e_y;
                    s_wr_d = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign y        = c_q.y;
    assign done     = c_q.done;
    assign overflow = c_q.ovf;

    AST_LEVELS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (m_level == s_level) && (m_full == s_full) && (m_empty == s_empty)); // R4
    AST_CALL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (m_push_d) |=> (cur_state == '0) && (cur_mod == $past(e_callee)));   // R4
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);                                                      // R6
    AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(y) && $stable(cur_mod) && $stable(cur_state));      // R6
    AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);                                              // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(y) && $stable(cur_mod) && $stable(cur_state));      // R8

endmodule

// File: tb/nested_fsm_tb.sv
`timescale 1ns/1ps
module nested_fsm_tb;

    localparam int X_W = 2, Y_W = 4, MOD_W = 2, ST_W = 3, DEPTH = 4, SEG_W = 1;
    localparam int AW = SEG_W + MOD_W + ST_W + X_W;
    localparam int EW = 2 + MOD_W + Y_W + ST_W;
    localparam int ENT = 1 << AW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run = 1'b0;
    logic [SEG_W-1:0] seg = '0;
    logic [X_W-1:0]   x = '0;
    logic             cfg_we = 1'b0;
    logic [AW-1:0]    cfg_addr = '0;
    logic [EW-1:0]    cfg_data = '0;
    logic [Y_W-1:0]   y;
    logic             done, overflow;
    logic [MOD_W-1:0] cur_mod;
    logic [ST_W-1:0]  cur_state;

    always #10 clk = ~clk;

    nested_fsm u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .seg(seg), .x(x),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .y(y), .done(done), .overflow(overflow),
        .cur_mod(cur_mod), .cur_state(cur_state)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    // Reference model
    logic [EW-1:0]    tbl [ENT];
    logic [MOD_W-1:0] mstk [DEPTH];
    logic [ST_W-1:0]  sstk [DEPTH];
    int               sp;
    logic [Y_W-1:0]   ey;
    bit               edone, eovf;

    function automatic logic [EW-1:0] mk(int op, int callee, int yv, int st);
        return {2'(op), MOD_W'(callee), Y_W'(yv), ST_W'(st)};
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        sp = 0; mstk[0] = '0; sstk[0] = '0; ey = '0; edone = 0; eovf = 0;
    endtask

    task automatic model_step(logic r, logic [SEG_W-1:0] s, logic [X_W-1:0] xv,
                              logic we, logic [AW-1:0] a, logic [EW-1:0] d);
        logic [EW-1:0] e;
        bit acc;
        acc = we && (!r || edone);
        e = tbl[{s, mstk[sp], sstk[sp], xv}];
        if (r && !edone) begin
            case (e[EW-1 -: 2])
                2'd1: begin
                    if (sp == DEPTH - 1) eovf = 1;
                    else begin
                        sstk[sp] = e[ST_W-1:0];
                        sp++;
                        mstk[sp] = e[ST_W+Y_W +: MOD_W];
                        sstk[sp] = '0;
                        ey = e[ST_W +: Y_W];
                    end
                end
                2'd2: begin
                    ey = e[ST_W +: Y_W];
                    if (sp == 0) edone = 1;
                    else sp--;
                end
                default: begin
                    sstk[sp] = e[ST_W-1:0];
                    ey = e[ST_W +: Y_W];
                end
            endcase
        end
        if (acc) tbl[a] = d;
    endtask

    task automatic compare_all();
        chk("R2/R3 y", int'(y), int'(ey));
        chk("R4 module", int'(cur_mod), int'(mstk[sp]));
        chk("R5 state", int'(cur_state), int'(sstk[sp]));
        chk("R6 done", int'(done), int'(edone));
        chk("R7 overflow", int'(overflow), int'(eovf));
    endtask

    task automatic cyc(logic r, logic [SEG_W-1:0] s, logic [X_W-1:0] xv,
                       logic we, logic [AW-1:0] a, logic [EW-1:0] d);
        run = r; seg = s; x = xv; cfg_we = we; cfg_addr = a; cfg_data = d;
        model_step(r, s, xv, we, a, d);
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; run = 1'b0; cfg_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
    endtask

    task automatic fill_const(logic [EW-1:0] d);
        for (int i = 0; i < ENT; i++) cyc(1'b0, '0, '0, 1'b1, AW'(i), d);
        cfg_we = 1'b0;
    endtask

    function automatic logic [EW-1:0] rnd_entry();
        int r = $urandom % 10;
        int op = (r < 6) ? 0 : (r < 8) ? 1 : (r < 9) ? 2 : 3;
        return mk(op, $urandom % 4, $urandom % 16, $urandom % 8);
    endfunction

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = int'($urandom(32'd4242));
        model_reset();
        for (int i = 0; i < ENT; i++) tbl[i] = '0;

        // R1: reset state
        do_reset();
        chk("R1 y", int'(y), 0);
        chk("R1 module", int'(cur_mod), 0);
        chk("R1 state", int'(cur_state), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 overflow", int'(overflow), 0);

        // R4 / R7: nest calls until full, then one refused call
        fill_const(mk(1, 1, 5, 6));
        do_reset();
        for (int i = 0; i < DEPTH - 1; i++) cyc(1'b1, '0, '0, 1'b0, '0, '0);
        chk("R4 callee entered at state 0", int'(cur_state), 0);
        chk("R4 callee module", int'(cur_mod), 1);
        chk("R7 no overflow yet", int'(overflow), 0);
        cyc(1'b1, '0, '0, 1'b0, '0, '0);
        chk("R7 overflow set", int'(overflow), 1);
        chk("R7 y unchanged", int'(y), 5);

        // R5 / R6: returns resume saved states, outermost return finishes
        fill_const(mk(2, 0, 9, 0));
        cyc(1'b1, '0, '0, 1'b0, '0, '0);
        chk("R5 resume at saved state", int'(cur_state), 6);
        for (int i = 0; i < DEPTH - 2; i++) cyc(1'b1, '0, '0, 1'b0, '0, '0);
        chk("R5 back at outermost", int'(cur_mod), 0);
        cyc(1'b1, '0, '0, 1'b0, '0, '0);
        chk("R6 done raised", int'(done), 1);
        fill_const(mk(0, 0, 12, 3));
        for (int i = 0; i < 3; i++) cyc(1'b1, '0, 2'(i), 1'b0, '0, '0);
        chk("R6 frozen y", int'(y), 9);
        chk("R7 overflow sticky", int'(overflow), 1);

        // R9: write during an active cycle is dropped
        do_reset();
        fill_const(mk(0, 0, 3, 1));
        cyc(1'b1, '0, '0, 1'b1, AW'({1'b0, 2'd0, 3'd1, 2'd0}), mk(0, 0, 10, 2));
        cyc(1'b1, '0, '0, 1'b0, '0, '0);
        chk("R9 write while running ignored", int'(y), 3);
        chk("R9 state from old entry", int'(cur_state), 1);

        // R8: idle holds everything
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'(i), 2'(i), 1'b0, '0, '0);
        chk("R8 idle y", int'(y), 3);
        chk("R8 idle state", int'(cur_state), 1);

        // R10: segment switch redirects next step
        do_reset();
        fill_const(mk(0, 0, 1, 0));
        cyc(1'b0, '0, '0, 1'b1, AW'({1'b1, 2'd0, 3'd0, 2'd0}), mk(0, 0, 2, 0));
        cyc(1'b1, 1'b0, '0, 1'b0, '0, '0);
        chk("R10 segment 0", int'(y), 1);
        cyc(1'b1, 1'b1, '0, 1'b0, '0, '0);
        chk("R10 segment 1", int'(y), 2);

        // Constrained random rounds
        for (int round = 0; round < 14; round++) begin
            do_reset();
            for (int i = 0; i < ENT; i++) cyc(1'b0, '0, '0, 1'b1, AW'(i), rnd_entry());
            for (int k = 0; k < 400; k++) begin
                logic r  = ($urandom % 10) != 0;
                logic we = ($urandom % 8) == 0;
                cyc(r, SEG_W'($urandom), X_W'($urandom), we, AW'($urandom), rnd_entry());
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule